// File: doc/BRIEF.md
# Count-Based Transaction Commit Checker

This block decides whether a transaction in a persistent-memory log was committed without relying on a separate commit record. It has two independent halves.

The write-side tagger takes a start pulse carrying a transaction identifier and a block total. It then emits that many log blocks over a valid/ready handshake. Every block carries the identifier. Exactly one block, the last one emitted, carries the total in its count field, and all the others carry zero. Because commit no longer depends on one ordered write, the blocks may reach memory in any order.

The recovery-side checker is armed by a scan-start pulse. It consumes scanned log entries (identifier plus count field) into a small associative table. For each identifier it keeps the recorded count and a tally of the blocks seen. After a scan-done pulse it reports one verdict per stored identifier, in ascending identifier order, and then raises a done flag. A transaction is committed only when its recorded count is non-zero, matches its tally, and was never contradicted.

Top module: `txcount_commit`

## Requirements
- R1: While the tagger has a transaction in flight, `blkValid` is high and every emitted block carries the identifier latched at start. While `blkReady` is low, `blkValid`, `blkTxId` and `blkCount` hold steady.
- R2: A transaction started with total N (N ≥ 1) produces exactly N handshakes. The first N−1 blocks carry count 0 and the N-th carries N. `blkValid` is low in the cycle after the N-th handshake.
- R3: A start pulse is ignored while a transaction is in flight, and also when its total is 0.
- R4: Between scan-start and scan-done, each entry with `entValid` high adds one to the tally of its identifier. A non-zero count field sets the recorded count of that identifier when none has been recorded yet.
- R5: A transaction is reported committed (`verdictCommit` = 1) when its recorded count is non-zero, equals its tally, and is not in conflict.
- R6: A transaction whose entries all carried count 0 is reported not committed.
- R7: A second non-zero count for an identifier that differs from the recorded count marks a conflict, and the transaction is reported not committed.
- R8: After scan-done is sampled, verdicts appear one per cycle in strictly ascending identifier order. The first verdict is valid in the cycle after the scan-done edge. `scanFinished` rises in the cycle after the last verdict, or one cycle after scan-done when the table is empty.
- R9: The table holds DEPTH (16) identifiers. An entry for a new identifier that arrives when the table is full sets `tableOverflow` and is discarded, so no verdict is reported for it.
- R10: A scan-start pulse empties the table and clears `tableOverflow`, `scanFinished` and `verdictValid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | Start pulse for a new outgoing transaction |
| wrTxId | input | ID_W | Identifier of the transaction to tag |
| wrTotal | input | CNT_W | Number of blocks in the transaction |
| wrBusy | output | 1 | Tagger has a transaction in flight |
| blkValid | output | 1 | Tagged block available |
| blkReady | input | 1 | Downstream accepts the tagged block |
| blkTxId | output | ID_W | Identifier stamped on the block |
| blkCount | output | CNT_W | Count field of the block (total on last, else 0) |
| scanStart | input | 1 | Clears the table and arms collection |
| entValid | input | 1 | Scanned log entry present |
| entTxId | input | ID_W | Identifier of the scanned entry |
| entCount | input | CNT_W | Count field of the scanned entry |
| scanDone | input | 1 | End of the log scan |
| verdictValid | output | 1 | Verdict strobe |
| verdictTxId | output | ID_W | Identifier being reported |
| verdictCommit | output | 1 | 1 = committed, 0 = not committed |
| scanFinished | output | 1 | All verdicts reported |
| tableOverflow | output | 1 | More distinct identifiers than table entries |

## Verification
The tagger's outputs come straight from its registers. Its block fields are therefore checked at the falling edge before each handshake edge, and its idle state is checked at the falling edge right after the final handshake. On the recovery side, an entry's effect is visible one edge after it is presented. The bench counts falling edges from the scan-done edge: no verdict at edge 0, the k-th verdict at edge k, and `scanFinished` at edge N+1. A verdict arriving a cycle early or late therefore counts as a miscompare. Overflow and clearing are read one edge after the offending entry or the scan-start pulse.

// File: rtl/commit_pkg.sv
package commit_pkg;
  typedef struct packed {
    logic clearTbl;
    logic acceptEnt;
    logic emitOne;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_WALK,
    ST_DONE
  } scanState_t;
endpackage

// File: rtl/log_tagger.sv
module log_tagger #(
  parameter int ID_W  = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrStart,
  input  logic [ID_W-1:0]  wrTxId,
  input  logic [CNT_W-1:0] wrTotal,
  output logic             wrBusy,
  output logic             blkValid,
  input  logic             blkReady,
  output logic [ID_W-1:0]  blkTxId,
  output logic [CNT_W-1:0] blkCount
);
  logic             busy;
  logic [ID_W-1:0]  curId;
  logic [CNT_W-1:0] curTotal;
  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      curId     <= '0;
      curTotal  <= '0;
      remaining <= '0;
    end else if (!busy) begin
      if (wrStart && wrTotal != '0) begin
        busy      <= 1'b1;
        curId     <= wrTxId;
        curTotal  <= wrTotal;
        remaining <= wrTotal;
      end
    end else if (blkReady) begin
      remaining <= remaining - CNT_W'(1);
      if (remaining == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assign wrBusy   = busy;
  assign blkValid = busy;
  assign blkTxId  = curId;
  assign blkCount = (remaining == CNT_W'(1)) ? curTotal : '0;
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import commit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scanStart,
  input  logic       scanDone,
  input  logic       anyLeft,
  output ctlStrobe_t stb,
  output logic       scanFinished
);
  scanState_t state, nextState;

  always_comb begin
    stb           = '0;
    stb.clearTbl  = scanStart;
    stb.acceptEnt = (state == ST_COLLECT) && !scanStart;
    stb.emitOne   = (state == ST_WALK) && anyLeft && !scanStart;
    nextState     = state;
    if (scanStart) begin
      nextState = ST_COLLECT;
    end else begin
      case (state)
        ST_COLLECT: if (scanDone) nextState = ST_WALK;
        ST_WALK:    if (!anyLeft) nextState = ST_DONE;
        default:    nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign scanFinished = (state == ST_DONE);
endmodule

// File: rtl/commit_table.sv
module commit_table
  import commit_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int CNT_W = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       stb,
  input  logic             entValid,
  input  logic [ID_W-1:0]  entTxId,
  input  logic [CNT_W-1:0] entCount,
  output logic             anyLeft,
  output logic             verdictValid,
  output logic [ID_W-1:0]  verdictTxId,
  output logic             verdictCommit,
  output logic             tableOverflow
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             rowVld   [DEPTH];
  logic             rowShown [DEPTH];
  logic             rowErr   [DEPTH];
  logic [ID_W-1:0]  rowId    [DEPTH];
  logic [CNT_W-1:0] rowRec   [DEPTH];
  logic [CNT_W-1:0] rowTally [DEPTH];

  logic             hit, freeFound;
  logic [IDX_W-1:0] hitIdx, freeIdx, bestIdx;
  logic [ID_W-1:0]  bestId;

  always_comb begin
    hit = 1'b0; hitIdx = '0; freeFound = 1'b0; freeIdx = '0;
    anyLeft = 1'b0; bestIdx = '0; bestId = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rowVld[i] && rowId[i] == entTxId && !hit) begin
        hit = 1'b1; hitIdx = IDX_W'(i);
      end
      if (!rowVld[i] && !freeFound) begin
        freeFound = 1'b1; freeIdx = IDX_W'(i);
      end
      if (rowVld[i] && !rowShown[i] && (!anyLeft || rowId[i] < bestId)) begin
        anyLeft = 1'b1; bestIdx = IDX_W'(i); bestId = rowId[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clearTbl) begin
      for (int i = 0; i < DEPTH; i++) begin
        rowVld[i] <= 1'b0; rowShown[i] <= 1'b0; rowErr[i] <= 1'b0;
        rowId[i]  <= '0;   rowRec[i]   <= '0;   rowTally[i] <= '0;
      end
      tableOverflow <= 1'b0;
      verdictValid  <= 1'b0;
      verdictTxId   <= '0;
      verdictCommit <= 1'b0;
    end else begin
      verdictValid <= stb.emitOne;
      if (stb.emitOne) begin
        verdictTxId      <= bestId;
        verdictCommit    <= !rowErr[bestIdx] && rowRec[bestIdx] != '0 &&
                            rowRec[bestIdx] == rowTally[bestIdx];
        rowShown[bestIdx] <= 1'b1;
      end
      if (stb.acceptEnt && entValid) begin
        if (hit) begin
          if (!(&rowTally[hitIdx])) rowTally[hitIdx] <= rowTally[hitIdx] + CNT_W'(1);
          if (entCount != '0) begin
            if (rowRec[hitIdx] == '0)           rowRec[hitIdx] <= entCount;
            else if (rowRec[hitIdx] != entCount) rowErr[hitIdx] <= 1'b1;
          end
        end else if (freeFound) begin
          rowVld[freeIdx]   <= 1'b1;
          rowId[freeIdx]    <= entTxId;
          rowRec[freeIdx]   <= entCount;
          rowTally[freeIdx] <= CNT_W'(1);
          rowErr[freeIdx]   <= 1'b0;
          rowShown[freeIdx] <= 1'b0;
        end else begin
          tableOverflow <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/txcount_commit.sv
module txcount_commit
  import commit_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int CNT_W = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrStart,
  input  logic [ID_W-1:0]  wrTxId,
  input  logic [CNT_W-1:0] wrTotal,
  output logic             wrBusy,
  output logic             blkValid,
  input  logic             blkReady,
  output logic [ID_W-1:0]  blkTxId,
  output logic [CNT_W-1:0] blkCount,
  input  logic             scanStart,
  input  logic             entValid,
  input  logic [ID_W-1:0]  entTxId,
  input  logic [CNT_W-1:0] entCount,
  input  logic             scanDone,
  output logic             verdictValid,
  output logic [ID_W-1:0]  verdictTxId,
  output logic             verdictCommit,
  output logic             scanFinished,
  output logic             tableOverflow
);
  ctlStrobe_t stb;
  logic       anyLeft;

  log_tagger #(.ID_W(ID_W), .CNT_W(CNT_W)) u_tagger (
    .clk(clk), .rst_n(rst_n), .wrStart(wrStart), .wrTxId(wrTxId),
    .wrTotal(wrTotal), .wrBusy(wrBusy), .blkValid(blkValid),
    .blkReady(blkReady), .blkTxId(blkTxId), .blkCount(blkCount)
  );

  scan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .scanStart(scanStart), .scanDone(scanDone),
    .anyLeft(anyLeft), .stb(stb), .scanFinished(scanFinished)
  );

  commit_table #(.ID_W(ID_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_table (
    .clk(clk), .rst_n(rst_n), .stb(stb), .entValid(entValid),
    .entTxId(entTxId), .entCount(entCount), .anyLeft(anyLeft),
    .verdictValid(verdictValid), .verdictTxId(verdictTxId),
    .verdictCommit(verdictCommit), .tableOverflow(tableOverflow)
  );
endmodule

// File: rtl/txcount_commit_checks.sv
module txcount_commit_checks #(
  parameter int ID_W  = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blkValid,
  input logic             blkReady,
  input logic [ID_W-1:0]  blkTxId,
  input logic [CNT_W-1:0] blkCount,
  input logic             scanStart,
  input logic             verdictValid,
  input logic [ID_W-1:0]  verdictTxId,
  input logic             scanFinished,
  input logic             tableOverflow
);
  a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    blkValid && !blkReady |=> blkValid && $stable(blkTxId) && $stable(blkCount));

  a_r2_total_ends_tx: assert property (@(posedge clk) disable iff (!rst_n)
    blkValid && blkReady && blkCount != '0 |=> !blkValid);

  a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    verdictValid && $past(verdictValid) && !$past(scanStart, 2) |-> verdictTxId > $past(verdictTxId));

  a_r8_no_verdict_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(verdictValid && scanFinished));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    scanStart |=> !scanFinished && !tableOverflow && !verdictValid);

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tableOverflow && !scanStart |=> tableOverflow);
endmodule

bind txcount_commit txcount_commit_checks #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/txcount_commit_tb.sv
`timescale 1ns/1ps
module txcount_commit_tb;
  localparam int ID_W = 8, CNT_W = 8, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wrStart = 0, blkReady = 0, scanStart = 0, entValid = 0, scanDone = 0;
  logic [ID_W-1:0] wrTxId = '0, entTxId = '0;
  logic [CNT_W-1:0] wrTotal = '0, entCount = '0;
  logic wrBusy, blkValid, verdictValid, verdictCommit, scanFinished, tableOverflow;
  logic [ID_W-1:0] blkTxId, verdictTxId;
  logic [CNT_W-1:0] blkCount;

  always #5 clk = ~clk;

  txcount_commit #(.ID_W(ID_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_dut (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // stimulus: {id, count}; interleaved blocks of five transactions
  localparam logic [15:0] SCAN_VEC [10] = '{
    {8'd9, 8'd0}, {8'd2, 8'd3}, {8'd5, 8'd0}, {8'd9, 8'd3}, {8'd7, 8'd2},
    {8'd1, 8'd1}, {8'd2, 8'd0}, {8'd9, 8'd0}, {8'd5, 8'd0}, {8'd7, 8'd3}};
  // expected verdicts in ascending order: {id, commit}
  localparam logic [8:0] EXP_VERD [5] = '{
    {8'd1, 1'b1}, {8'd2, 1'b0}, {8'd5, 1'b0}, {8'd7, 1'b0}, {8'd9, 1'b1}};

  logic [ID_W-1:0] gotId [32];
  logic            gotCommit [32];
  int              gotCyc [32];
  int              gotN, doneCyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startScan();
    @(negedge clk) scanStart = 1;
    @(negedge clk) scanStart = 0;
  endtask

  task automatic feed(input logic [ID_W-1:0] id, input logic [CNT_W-1:0] c);
    entValid = 1; entTxId = id; entCount = c;
    @(negedge clk) entValid = 0;
  endtask

  task automatic finishScan();
    scanDone = 1;
    @(negedge clk) scanDone = 0;
    gotN = 0; doneCyc = -1;
    chk(!verdictValid, "R8 no verdict at scan-done edge", int'(verdictValid), 0);
    for (int cyc = 1; cyc < 40; cyc++) begin
      @(negedge clk);
      if (verdictValid) begin
        gotId[gotN] = verdictTxId; gotCommit[gotN] = verdictCommit;
        gotCyc[gotN] = cyc; gotN++;
      end
      if (scanFinished) begin doneCyc = cyc; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(!blkValid && !wrBusy, "R1 reset idle tagger", int'(blkValid), 0);
    chk(!verdictValid && !scanFinished, "R8 reset no verdict", int'(scanFinished), 0);
    chk(!tableOverflow, "R9 reset overflow clear", int'(tableOverflow), 0);

    // vector table walk: one scan of interleaved entries
    startScan();
    foreach (SCAN_VEC[i]) feed(SCAN_VEC[i][15:8], SCAN_VEC[i][7:0]);
    finishScan();
    chk(gotN == 5, "R4 verdict count", gotN, 5);
    for (int k = 0; k < 5 && k < gotN; k++) begin
      chk(gotId[k] == EXP_VERD[k][8:1], "R8 ascending id", int'(gotId[k]), int'(EXP_VERD[k][8:1]));
      chk(gotCommit[k] == EXP_VERD[k][0], "R5 R6 R7 verdict", int'(gotCommit[k]), int'(EXP_VERD[k][0]));
      chk(gotCyc[k] == k + 1, "R8 one verdict per cycle", gotCyc[k], k + 1);
    end
    chk(doneCyc == 6, "R8 done after last verdict", doneCyc, 6);
    chk(!tableOverflow, "R9 no overflow with 5 ids", int'(tableOverflow), 0);

    // R10: rescan clears table; empty scan finishes one cycle after done
    startScan();
    chk(!scanFinished, "R10 done cleared", int'(scanFinished), 0);
    finishScan();
    chk(gotN == 0, "R10 table emptied", gotN, 0);
    chk(doneCyc == 1, "R8 empty table done", doneCyc, 1);

    // R9: 17 distinct ids, 16 down to 0; id 0 must be discarded
    startScan();
    for (int i = 16; i >= 0; i--) begin
      feed(ID_W'(i), CNT_W'(1));
      if (i == 1) chk(!tableOverflow, "R9 overflow not yet", int'(tableOverflow), 0);
    end
    chk(tableOverflow, "R9 overflow set", int'(tableOverflow), 1);
    finishScan();
    chk(gotN == DEPTH, "R9 only stored ids reported", gotN, DEPTH);
    for (int k = 0; k < gotN; k++)
      chk(gotId[k] == ID_W'(k + 1) && gotCommit[k], "R9 R5 stored id committed", int'(gotId[k]), k + 1);
    startScan();
    chk(!tableOverflow, "R10 overflow cleared", int'(tableOverflow), 0);

    // R1 R2 R3: tagger with stalls and an ignored start
    @(negedge clk) begin wrStart = 1; wrTxId = 8'h33; wrTotal = 8'd3; end
    @(negedge clk) wrStart = 0;
    chk(blkValid && blkTxId == 8'h33, "R1 tagged id", int'(blkTxId), 8'h33);
    wrStart = 1; wrTxId = 8'h44; wrTotal = 8'd5;
    @(negedge clk) wrStart = 0;
    chk(blkTxId == 8'h33, "R3 start while busy ignored", int'(blkTxId), 8'h33);
    chk(blkCount == 0, "R1 held during stall", int'(blkCount), 0);
    for (int k = 0; k < 3; k++) begin
      chk(blkValid && blkTxId == 8'h33, "R1 id on block", int'(blkTxId), 8'h33);
      chk(blkCount == ((k == 2) ? 8'd3 : 8'd0), "R2 count field", int'(blkCount), (k == 2) ? 3 : 0);
      blkReady = 1;
      @(negedge clk) blkReady = 0;
      if (k == 0) @(negedge clk);
    end
    chk(!blkValid, "R2 exactly total blocks", int'(blkValid), 0);
    wrStart = 1; wrTxId = 8'h55; wrTotal = 8'd0;
    @(negedge clk) wrStart = 0;
    chk(!blkValid, "R3 zero total ignored", int'(blkValid), 0);
    wrStart = 1; wrTxId = 8'h56; wrTotal = 8'd1;
    @(negedge clk) wrStart = 0;
    chk(blkValid && blkCount == 8'd1 && blkTxId == 8'h56, "R2 single block carries total", int'(blkCount), 1);
    blkReady = 1;
    @(negedge clk) blkReady = 0;
    chk(!blkValid, "R2 single block ends", int'(blkValid), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule